// File: doc/BRIEF.md
# Two-Instruction RV64 Execute Core

This block is a very small 64-bit integer execution engine. It accepts one 32-bit instruction word at a time over a valid/ready stream. It executes two operations: add-immediate and load-doubleword. Every other encoding is rejected.

The core holds 32 general registers of 64 bits each and a 64-bit program counter. Register 0 is hard-wired to zero. An add-immediate finishes in the same cycle it is accepted. A load sends one request on a valid/ready request channel. It then waits, for as long as needed, for a valid/ready response that carries the doubleword. While a load is in flight the instruction stream is back-pressured: `insn_ready` stays low until the response has been taken.

Each channel follows the usual rules. A transfer happens on a rising edge where both valid and ready are high. Once the core raises `mem_req_valid`, it holds that signal and `mem_req_addr` steady until the request is accepted. The core offers `mem_rsp_ready` only while it is waiting for load data.

Top module: `rvmini_core`

## Requirements
- R1: Under synchronous active-low reset, `pc_o` takes the value of parameter RESET_VEC, all 32 registers become zero, `insn_ready` is high, and `mem_req_valid`, `mem_rsp_ready`, `retire_o` and `illegal_o` are low.
- R2: An instruction word with bits [6:0]=0010011 and bits [14:12]=000 is add-immediate. It writes register bits[11:7] with register bits[19:15] plus bits[31:20] sign-extended to 64 bits, and the sum wraps modulo 2^64.
- R3: An instruction word with bits [6:0]=0000011 and bits [14:12]=011 is load-doubleword. It issues `mem_req_addr` = register bits[19:15] + sign-extended bits[31:20], and writes the response data unchanged into register bits[11:7].
- R4: Register 0 always reads as zero. Writes to it, from either an add or a load, are discarded.
- R5: Any other instruction word raises `illegal_o` in the cycle after acceptance, changes no register, and leaves `pc_o` unchanged.
- R6: Each completed instruction raises `retire_o` for one cycle and advances `pc_o` by 4 at the same edge. `pc_o` changes at no other time.
- R7: `insn_ready` is high only while no load is in flight. An add-immediate leaves the core ready again in the very next cycle, and a word offered while a load is in flight is not taken.
- R8: After the core raises `mem_req_valid`, that signal and `mem_req_addr` stay stable until a cycle with `mem_req_ready` high.
- R9: `mem_rsp_ready` is high only after the request has been accepted and until a response arrives. The core waits any number of cycles for `mem_rsp_valid`.
- R10: `retire_o` and `illegal_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| insn_valid | input | 1 | Instruction word offered |
| insn_ready | output | 1 | Core can accept an instruction |
| insn_data | input | 32 | Instruction word |
| mem_req_valid | output | 1 | Load request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Load byte address |
| mem_rsp_valid | input | 1 | Load data present |
| mem_rsp_ready | output | 1 | Core waiting for load data |
| mem_rsp_data | input | 64 | Load data |
| pc_o | output | 64 | Program counter |
| retire_o | output | 1 | Pulse: instruction completed |
| illegal_o | output | 1 | Pulse: instruction rejected |

## Verification
Some properties are checked by the assertions on every cycle:
- The program counter moves only on a retire pulse, and then by exactly 4.
- It holds on a rejected word.
- The two pulses never coincide.
- Exactly one of the three channel-ready or channel-valid phases is active at a time.
- A pending request keeps its address steady.
- The core keeps waiting for a late response.

The arithmetic itself can only be shown by the bench scenarios. These cover the sign-extended sums with wrap-around, load data landing in the right register, discarded writes to register 0, and the untouched register file after rejected encodings. The bench observes register contents through the load address a register produces.

// File: rtl/rvmini_pkg.sv
package rvmini_pkg;

  localparam int NREG = 32;
  localparam int RIDX_W = $clog2(NREG);

  localparam logic [6:0] OPC_OPIMM = 7'b0010011;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [2:0] F3_ADD    = 3'b000;
  localparam logic [2:0] F3_DWORD  = 3'b011;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_ADDI,
    OP_LD
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT
  } state_e;

endpackage

// File: rtl/rvmini_decode.sv
module rvmini_decode
  import rvmini_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0]       insn,
  output op_e               op,
  output logic [RIDX_W-1:0] rd,
  output logic [RIDX_W-1:0] rs1,
  output logic [XLEN-1:0]   imm
);

  localparam int IMM_W = 12;

  logic [6:0] opcode;
  logic [2:0] funct3;

  assign opcode = insn[6:0];
  assign funct3 = insn[14:12];
  assign rd     = insn[11:7];
  assign rs1    = insn[19:15];
  assign imm    = {{(XLEN-IMM_W){insn[31]}}, insn[31:20]};

  always_comb begin
    op = OP_NONE;
    if (opcode == OPC_OPIMM && funct3 == F3_ADD) begin
      op = OP_ADDI;
    end else if (opcode == OPC_LOAD && funct3 == F3_DWORD) begin
      op = OP_LD;
    end
  end

endmodule

// File: rtl/rvmini_regfile.sv
module rvmini_regfile
  import rvmini_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RIDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]   rd_data,
  input  logic              wr_en,
  input  logic [RIDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]   wr_data
);

  logic [XLEN-1:0] rd_vec [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    if (g == 0) begin : g_zero
      assign rd_vec[g] = '0;
    end else begin : g_reg
      logic [XLEN-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q <= '0;
        end else if (wr_en && wr_idx == RIDX_W'(g)) begin
          q <= wr_data;
        end
      end
      assign rd_vec[g] = q;
    end
  end

  assign rd_data = rd_vec[rd_idx];

endmodule

// File: rtl/rvmini_ctrl.sv
module rvmini_ctrl
  import rvmini_pkg::*;
#(
  parameter int              XLEN      = 64,
  parameter logic [XLEN-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  output logic              insn_ready,
  input  op_e               op,
  input  logic [RIDX_W-1:0] dec_rd,
  input  logic [XLEN-1:0]   dec_imm,
  input  logic [XLEN-1:0]   rs1_val,
  output logic              rf_wr_en,
  output logic [RIDX_W-1:0] rf_wr_idx,
  output logic [XLEN-1:0]   rf_wr_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [XLEN-1:0]   mem_rsp_data,
  output logic [XLEN-1:0]   pc,
  output logic              retire,
  output logic              illegal
);

  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  state_e            state_q;
  logic [XLEN-1:0]   pc_q;
  logic [XLEN-1:0]   addr_q;
  logic [RIDX_W-1:0] ld_rd_q;
  logic              retire_q;
  logic              illegal_q;

  logic            accept;
  logic            rsp_fire;
  logic            addi_done;
  logic [XLEN-1:0] sum;

  // one adder serves both the add result and the load address
  assign sum        = rs1_val + dec_imm;
  assign insn_ready = (state_q == ST_IDLE);
  assign accept     = insn_valid && insn_ready;
  assign addi_done  = accept && (op == OP_ADDI);

  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_rsp_ready = (state_q == ST_WAIT);
  assign rsp_fire      = mem_rsp_valid && mem_rsp_ready;

  assign rf_wr_en   = addi_done || rsp_fire;
  assign rf_wr_idx  = rsp_fire ? ld_rd_q : dec_rd;
  assign rf_wr_data = rsp_fire ? mem_rsp_data : sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pc_q      <= RESET_VEC;
      addr_q    <= '0;
      ld_rd_q   <= '0;
      retire_q  <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      retire_q  <= addi_done || rsp_fire;
      illegal_q <= accept && (op == OP_NONE);
      unique case (state_q)
        ST_IDLE: begin
          if (addi_done) begin
            pc_q <= pc_q + PC_STEP;
          end else if (accept && op == OP_LD) begin
            addr_q  <= sum;
            ld_rd_q <= dec_rd;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            pc_q    <= pc_q + PC_STEP;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pc      = pc_q;
  assign retire  = retire_q;
  assign illegal = illegal_q;

endmodule

// File: rtl/rvmini_core.sv
module rvmini_core
  import rvmini_pkg::*;
#(
  parameter int              XLEN      = 64,
  parameter logic [XLEN-1:0] RESET_VEC = XLEN'(64'h0000_0000_8000_0000)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_valid,
  output logic            insn_ready,
  input  logic [31:0]     insn_data,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  output logic            mem_rsp_ready,
  input  logic [XLEN-1:0] mem_rsp_data,
  output logic [XLEN-1:0] pc_o,
  output logic            retire_o,
  output logic            illegal_o
);

  op_e               dec_op;
  logic [RIDX_W-1:0] dec_rd;
  logic [RIDX_W-1:0] dec_rs1;
  logic [XLEN-1:0]   dec_imm;
  logic [XLEN-1:0]   rs1_val;
  logic              rf_wr_en;
  logic [RIDX_W-1:0] rf_wr_idx;
  logic [XLEN-1:0]   rf_wr_data;

  rvmini_decode #(.XLEN(XLEN)) u_dec (
    .insn (insn_data),
    .op   (dec_op),
    .rd   (dec_rd),
    .rs1  (dec_rs1),
    .imm  (dec_imm)
  );

  rvmini_regfile #(.XLEN(XLEN)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (dec_rs1),
    .rd_data (rs1_val),
    .wr_en   (rf_wr_en),
    .wr_idx  (rf_wr_idx),
    .wr_data (rf_wr_data)
  );

  rvmini_ctrl #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .insn_valid    (insn_valid),
    .insn_ready    (insn_ready),
    .op            (dec_op),
    .dec_rd        (dec_rd),
    .dec_imm       (dec_imm),
    .rs1_val       (rs1_val),
    .rf_wr_en      (rf_wr_en),
    .rf_wr_idx     (rf_wr_idx),
    .rf_wr_data    (rf_wr_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .mem_rsp_data  (mem_rsp_data),
    .pc            (pc_o),
    .retire        (retire_o),
    .illegal       (illegal_o)
  );

endmodule

// File: rtl/rvmini_core_chk.sv
module rvmini_core_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            insn_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [XLEN-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            mem_rsp_ready,
  input logic [XLEN-1:0] pc_o,
  input logic            retire_o,
  input logic            illegal_o
);

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    retire_o |-> pc_o == $past(pc_o) + XLEN'(4)); // R6

  AST_PC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_o |-> $stable(pc_o)); // R6

  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $stable(pc_o)); // R5

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire_o && illegal_o)); // R10

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({insn_ready, mem_req_valid, mem_rsp_ready}) == 1); // R7

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R8

  AST_REQ_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> mem_rsp_ready); // R9

  AST_RSP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready && !mem_rsp_valid |=> mem_rsp_ready && !retire_o); // R9

endmodule

bind rvmini_core rvmini_core_chk #(.XLEN(XLEN)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .insn_ready    (insn_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_ready (mem_rsp_ready),
  .pc_o          (pc_o),
  .retire_o      (retire_o),
  .illegal_o     (illegal_o)
);

// File: tb/rvmini_core_tb_top.sv
module rvmini_core_tb_top;

  localparam logic [63:0] RVEC = 64'h0000_0000_8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic        insn_ready;
  logic [31:0] insn_data = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [63:0] mem_rsp_data = '0;
  logic [63:0] pc_o;
  logic        retire_o;
  logic        illegal_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [63:0] m_regs [32];
  logic [63:0] m_pc;

  always #2 clk = ~clk;

  rvmini_core #(.XLEN(64), .RESET_VEC(RVEC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .insn_valid(insn_valid), .insn_ready(insn_ready), .insn_data(insn_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .pc_o(pc_o), .retire_o(retire_o), .illegal_o(illegal_o)
  );

  function automatic logic [63:0] memfn(input logic [63:0] a);
    return (a * 64'h9E37_79B9_7F4A_7C15) ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  function automatic logic [31:0] enc(input logic [11:0] imm, input logic [4:0] rs1,
                                      input logic [2:0] f3, input logic [4:0] rd,
                                      input logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive one instruction and play the memory side for a load
  task automatic run_insn(input logic [31:0] w, input int req_dly, input int rsp_dly,
                          input string tag);
    logic [4:0]  rd  = w[11:7];
    logic [4:0]  rs1 = w[19:15];
    logic [63:0] imm = {{52{w[31]}}, w[31:20]};
    bit is_addi = (w[6:0] == 7'b0010011) && (w[14:12] == 3'b000);
    bit is_ld   = (w[6:0] == 7'b0000011) && (w[14:12] == 3'b011);
    logic [63:0] val;
    @(negedge clk);
    while (!insn_ready) @(negedge clk);
    insn_valid = 1'b1;
    insn_data  = w;
    @(negedge clk);
    insn_valid = 1'b0;
    if (is_addi) begin
      val = m_regs[rs1] + imm;
      if (rd != 0) m_regs[rd] = val;
      m_pc = m_pc + 64'd4;
      chk(retire_o == 1'b1, "R6", "addi retire pulse", {63'd0, retire_o}, 64'd1);
      chk(pc_o == m_pc, "R6", "pc after addi", pc_o, m_pc);
      chk(insn_ready == 1'b1, "R7", "ready right after addi", {63'd0, insn_ready}, 64'd1);
    end else if (is_ld) begin
      val = m_regs[rs1] + imm;
      chk(mem_req_valid && mem_req_addr == val, tag, "load address", mem_req_addr, val);
      chk(insn_ready == 1'b0, "R7", "busy during load", {63'd0, insn_ready}, 64'd0);
      for (int i = 0; i < req_dly; i++) begin
        insn_valid = 1'b1;
        insn_data  = enc(12'h001, 5'd1, 3'b000, 5'd1, 7'b0010011);
        @(negedge clk);
        chk(mem_req_valid && mem_req_addr == val && !insn_ready, "R8", "request held",
            mem_req_addr, val);
      end
      insn_valid    = 1'b0;
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk(mem_rsp_ready && !mem_req_valid, "R9", "waiting for data", {63'd0, mem_rsp_ready}, 64'd1);
      for (int i = 0; i < rsp_dly; i++) begin
        @(negedge clk);
        chk(mem_rsp_ready && !retire_o && pc_o == m_pc, "R9", "still waiting",
            pc_o, m_pc);
      end
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = memfn(val);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (rd != 0) m_regs[rd] = memfn(val);
      m_pc = m_pc + 64'd4;
      chk(retire_o == 1'b1, "R6", "load retire pulse", {63'd0, retire_o}, 64'd1);
      chk(pc_o == m_pc, "R6", "pc after load", pc_o, m_pc);
    end else begin
      chk(illegal_o == 1'b1 && retire_o == 1'b0, "R5", "illegal pulse",
          {63'd0, illegal_o}, 64'd1);
      chk(pc_o == m_pc, "R5", "pc held on illegal", pc_o, m_pc);
    end
  endtask

  // observe a register via the address of a load into x0
  task automatic peek(input int idx, input string tag);
    run_insn(enc(12'h000, 5'(idx), 3'b011, 5'd0, 7'b0000011), idx % 3, idx % 2, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) m_regs[i] = '0;
    m_pc = RVEC;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pc_o == RVEC, "R1", "reset pc", pc_o, RVEC);
    chk(insn_ready && !mem_req_valid && !mem_rsp_ready && !retire_o && !illegal_o,
        "R1", "reset handshake state", {59'd0, insn_ready, mem_req_valid, mem_rsp_ready,
        retire_o, illegal_o}, 64'h10);
    rst_n = 1'b1;
    for (int i = 0; i < 32; i++) peek(i, "R1");

    // R2: add-immediate from x0 into every register, spread over both signs
    for (int r = 1; r < 32; r++)
      run_insn(enc(12'((r * 137 + 2000) % 4096), 5'd0, 3'b000, 5'(r), 7'b0010011), 0, 0, "R2");
    for (int r = 1; r < 32; r++)
      run_insn(enc(12'((r * 991) % 4096), 5'((r * 7) % 32), 3'b000, 5'(r), 7'b0010011), 0, 0, "R2");
    for (int i = 0; i < 32; i++) peek(i, "R2");

    // R2: wrap-around from all ones to zero, negative immediate
    run_insn(enc(12'hFFF, 5'd0, 3'b000, 5'd7, 7'b0010011), 0, 0, "R2");
    peek(7, "R2");
    run_insn(enc(12'h001, 5'd7, 3'b000, 5'd7, 7'b0010011), 0, 0, "R2");
    peek(7, "R2");
    run_insn(enc(12'h800, 5'd0, 3'b000, 5'd8, 7'b0010011), 0, 0, "R2");
    run_insn(enc(12'h7FF, 5'd8, 3'b000, 5'd8, 7'b0010011), 0, 0, "R2");
    peek(8, "R2");

    // R2: immediate sweep on a fixed base
    for (int k = 0; k < 4096; k += 13) begin
      run_insn(enc(12'(k), 5'd8, 3'b000, 5'd9, 7'b0010011), 0, 0, "R2");
      peek(9, "R2");
    end

    // R3: loads into each register with varied handshake delays
    for (int r = 1; r < 32; r++)
      run_insn(enc(12'((r * 301) % 4096), 5'((r * 5) % 32), 3'b011, 5'(r), 7'b0000011),
               r % 4, (r * 3) % 5, "R3");
    for (int i = 0; i < 32; i++) peek(i, "R3");

    // R4: writes to x0 are discarded
    run_insn(enc(12'h05A, 5'd3, 3'b011, 5'd0, 7'b0000011), 2, 3, "R3");
    peek(0, "R4");
    run_insn(enc(12'h123, 5'd4, 3'b000, 5'd0, 7'b0010011), 0, 0, "R4");
    peek(0, "R4");
    run_insn(enc(12'h010, 5'd0, 3'b011, 5'd12, 7'b0000011), 0, 0, "R4");
    peek(12, "R4");

    // R5: rejected encodings leave registers untouched
    for (int f = 0; f < 8; f++) begin
      if (f != 0) run_insn(enc(12'h0AB, 5'd2, 3'(f), 5'd3, 7'b0010011), 0, 0, "R5");
      if (f != 3) run_insn(enc(12'h0AB, 5'd2, 3'(f), 5'd3, 7'b0000011), 0, 0, "R5");
      peek(3, "R5");
    end
    run_insn(enc(12'h001, 5'd2, 3'b000, 5'd3, 7'b0110011), 0, 0, "R5");
    run_insn(enc(12'h001, 5'd2, 3'b011, 5'd3, 7'b0100011), 0, 0, "R5");
    run_insn(32'h0000_0000, 0, 0, "R5");
    run_insn(32'hFFFF_FFFF, 0, 0, "R5");
    peek(3, "R5");
    peek(1, "R7");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule